// File: doc/BRIEF.md
# Two-Wire Bus Clock Waveform Generator

This block times the serial clock of a two-wire bus master from the system clock. A single configuration word sets three values: a divider for the low phase, a divider for the high phase, and a power-of-two prescale exponent. Each phase lasts the divider shifted left by the exponent, plus a fixed number of extra source cycles set at build time.

A bit-level engine sets its two run qualifiers, enable and transfer-active. While both are high, the generator alternates low and high phases, starting with a low phase. At the last cycle of each phase it pulses a strobe, which the engine uses to step its own state. When either qualifier drops, the clock returns to released-high and the generator waits.

New configuration words can be written at any time. A new word is picked up only at the next low-phase boundary, so a phase is never cut short or stretched part way through.

Top module: `scl_wave_gen`

## Requirements
- R1: In the configuration word, bits [7:0] set the low-phase divider, bits [15:8] set the high-phase divider, and bits [19:16] set the prescale exponent. The word is captured on a clock edge where `cfgWrEn` is high.
- R2: Each low phase holds `sclOut` at 0 for exactly lowDiv × 2^exp + OFFSET clock cycles.
- R3: Each high phase inside a transfer holds `sclOut` at 1 for exactly highDiv × 2^exp + OFFSET clock cycles.
- R4: An exponent above MAX_EXP is stored as MAX_EXP.
- R5: Equal low and high dividers give low and high phases of equal length.
- R6: A word written during a phase does not change the current phase or the high phase that follows it. The word takes effect from the next low phase.
- R7: When `masterEn` or `xferActive` is low, `sclOut` is 1 from the next cycle on and `phaseDone` stays 0. Dropping either qualifier in the middle of a phase releases the clock on the next cycle.
- R8: `phaseDone` is high for exactly one cycle per phase, in the last cycle of that phase.
- R9: `sclOut` goes to 0 in the first cycle after both qualifiers become high.
- R10: During reset and just after it, `sclOut` is 1 and `phaseDone` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | Master enable qualifier |
| xferActive | input | 1 | Transfer in progress qualifier |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration word |
| sclOut | output | 1 | Serial clock level (1 = released) |
| phaseDone | output | 1 | One-cycle strobe at the last cycle of each phase |

## Verification
The configuration words are chosen to separate the effects on the phase lengths. Unequal dividers catch swapped fields. Zero dividers isolate the fixed offset. Full-scale dividers test the counter width, and an out-of-range exponent tests the clamp. Symmetric words confirm that both phases use the same formula. Directed runs do three more things: they write a new word part way through a low phase to show exactly which phase first uses it, they hold each qualifier low to confirm the idle level, and they cut a phase short to confirm the clock is released on the next cycle.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic loadLow;    // start a low phase, latch the pending word
    logic loadHigh;   // start a high phase from the latched word
    logic countDown;  // one more cycle of the current phase elapsed
  } strobe_t;

endpackage

// File: rtl/scl_wave_cfg.sv
module scl_wave_cfg #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 7,
  parameter int CFG_W   = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [CFG_W-1:0]                   wrData,
  output logic [DIV_W-1:0]                   lowDiv,
  output logic [DIV_W-1:0]                   highDiv,
  output logic [$clog2(MAX_EXP+1)-1:0]       expVal
);

  localparam int SEXP_W  = $clog2(MAX_EXP + 1);
  localparam int HIGH_LSB = DIV_W;
  localparam int EXP_LSB  = 2 * DIV_W;

  logic [EXP_W-1:0]  expField;
  logic [SEXP_W-1:0] expNext;

  assign expField = wrData[EXP_LSB +: EXP_W];

  // saturate only when the field can encode more than the limit
  generate
    if (((1 << EXP_W) - 1) > MAX_EXP) begin : g_clamp
      always_comb begin
        if (expField > EXP_W'(MAX_EXP)) expNext = SEXP_W'(MAX_EXP);
        else                            expNext = SEXP_W'(expField);
      end
    end else begin : g_pass
      assign expNext = SEXP_W'(expField);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowDiv  <= '0;
      highDiv <= '0;
      expVal  <= '0;
    end else if (wrEn) begin
      lowDiv  <= wrData[DIV_W-1:0];
      highDiv <= wrData[HIGH_LSB +: DIV_W];
      expVal  <= expNext;
    end
  end

endmodule

// File: rtl/scl_wave_dp.sv
module scl_wave_dp
  import scl_wave_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int MAX_EXP = 7,
  parameter int OFFSET  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  logic [DIV_W-1:0]             cfgLow,
  input  logic [DIV_W-1:0]             cfgHigh,
  input  logic [$clog2(MAX_EXP+1)-1:0] cfgExp,
  output logic                         cntZero
);

  localparam int SEXP_W = $clog2(MAX_EXP + 1);
  localparam int CNT_W  = DIV_W + MAX_EXP + 1;

  logic [DIV_W-1:0]  shHigh;
  logic [SEXP_W-1:0] shExp;
  logic [CNT_W-1:0]  cnt;

  // cycles in a phase minus one, so the counter ends on zero
  function automatic logic [CNT_W-1:0] phaseLast(
    input logic [DIV_W-1:0]  div,
    input logic [SEXP_W-1:0] ex
  );
    logic [CNT_W-1:0] scaled;
    scaled = CNT_W'(div) << ex;
    return scaled + CNT_W'(OFFSET - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shHigh <= '0;
      shExp  <= '0;
    end else if (strobe.loadLow) begin
      shHigh <= cfgHigh;
      shExp  <= cfgExp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadLow) begin
      cnt <= phaseLast(cfgLow, cfgExp);
    end else if (strobe.loadHigh) begin
      cnt <= phaseLast(shHigh, shExp);
    end else if (strobe.countDown) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

endmodule

// File: rtl/scl_wave_ctrl.sv
module scl_wave_ctrl
  import scl_wave_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    run,
  input  logic    cntZero,
  output strobe_t strobe,
  output logic    sclOut,
  output logic    phaseDone
);

  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (run) begin
          strobe.loadLow = 1'b1;
          phaseNext      = PH_LOW;
        end
      end
      PH_LOW: begin
        if (!run) begin
          phaseNext = PH_IDLE;
        end else if (cntZero) begin
          strobe.loadHigh = 1'b1;
          phaseNext       = PH_HIGH;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!run) begin
          phaseNext = PH_IDLE;
        end else if (cntZero) begin
          strobe.loadLow = 1'b1;
          phaseNext      = PH_LOW;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign sclOut    = (phase != PH_LOW);
  assign phaseDone = run && (phase != PH_IDLE) && cntZero;

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_wave_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 7,
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 4,
  parameter int CFG_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterEn,
  input  logic             xferActive,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             sclOut,
  output logic             phaseDone
);

  localparam int SEXP_W = $clog2(MAX_EXP + 1);

  logic              run;
  logic              cntZero;
  strobe_t           strobe;
  logic [DIV_W-1:0]  cfgLow;
  logic [DIV_W-1:0]  cfgHigh;
  logic [SEXP_W-1:0] cfgExp;

  assign run = masterEn && xferActive;

  scl_wave_cfg #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData),
    .lowDiv(cfgLow), .highDiv(cfgHigh), .expVal(cfgExp)
  );

  scl_wave_dp #(
    .DIV_W(DIV_W), .MAX_EXP(MAX_EXP), .OFFSET(OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgLow(cfgLow), .cfgHigh(cfgHigh), .cfgExp(cfgExp),
    .cntZero(cntZero)
  );

  scl_wave_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .cntZero(cntZero),
    .strobe(strobe), .sclOut(sclOut), .phaseDone(phaseDone)
  );

endmodule

// File: rtl/scl_wave_chk.sv
module scl_wave_chk (
  input logic clk,
  input logic rstN,
  input logic masterEn,
  input logic xferActive,
  input logic sclOut,
  input logic phaseDone
);

  logic run;
  assign run = masterEn && xferActive;

  // R7: without both qualifiers the clock is released next cycle
  a_r7_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> sclOut);

  // R7: an idle generator emits no phase strobe
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !phaseDone);

  // R9: a new run opens with a low phase
  a_r9_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |=> !sclOut);

  // R8: the strobe marks the last cycle, so the level flips after it
  a_r8_done_flips: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |=> (sclOut != $past(sclOut)));

  // R8: the strobe never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |=> !phaseDone);

  // R10: outputs stay at their idle values while reset is held
  a_r10_reset_idle: assert property (@(posedge clk)
    (!rstN && !$past(rstN)) |-> (sclOut && !phaseDone));

endmodule

bind scl_wave_gen scl_wave_chk u_chk (.*);

// File: tb/scl_wave_gen_test.sv
module scl_wave_gen_test;

  localparam int OFFSET  = 4;
  localparam int MAX_EXP = 7;
  localparam int LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterEn = 1'b0;
  logic        xferActive = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        sclOut;
  logic        phaseDone;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  scl_wave_gen #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) uut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .xferActive(xferActive),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .sclOut(sclOut), .phaseDone(phaseDone)
  );

  // R1 field layout: low [7:0], high [15:8], exponent [19:16]
  localparam logic [31:0] VEC [7] = '{
    32'h0000_0505,  // symmetric, exp 0
    32'h0001_0A03,  // unequal dividers, exp 1
    32'h0000_0000,  // offset only
    32'h0003_0102,  // low larger than high
    32'h0000_FFFF,  // full-scale dividers
    32'h0009_0201,  // exponent above limit
    32'h0002_0707   // symmetric, exp 2
  };

  function automatic int expLen(input int div, input int ex);
    int e;
    e = (ex > MAX_EXP) ? MAX_EXP : ex;
    return div * (1 << e) + OFFSET;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic writeCfg(input logic [31:0] w);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = w;
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  task automatic stopRun();
    @(negedge clk);
    masterEn   = 1'b0;
    xferActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // count one phase at the current level, starting at a sampled negedge
  task automatic countPhase(input logic lvl, output int len, output int pdCnt,
                            output logic lastPd);
    len = 0; pdCnt = 0; lastPd = 1'b0;
    while (sclOut == lvl && len < LIMIT) begin
      len++;
      pdCnt += int'(phaseDone);
      lastPd = phaseDone;
      @(negedge clk);
    end
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int   lowLen, highLen, pd, nextLen;
    logic lastPd;
    bit   bad;

    // R10 reset state
    repeat (3) @(negedge clk);
    check(sclOut === 1'b1, "R10 scl in reset", int'(sclOut), 1);
    check(phaseDone === 1'b0, "R10 done in reset", int'(phaseDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOut === 1'b1 && phaseDone === 1'b0, "R10 after reset", int'(sclOut), 1);

    // table walk: R1 R2 R3 R4 R5 R8 R9
    foreach (VEC[i]) begin
      int eL, eH;
      eL = expLen(int'(VEC[i][7:0]),  int'(VEC[i][19:16]));
      eH = expLen(int'(VEC[i][15:8]), int'(VEC[i][19:16]));
      writeCfg(VEC[i]);
      masterEn = 1'b1; xferActive = 1'b1;
      @(negedge clk);
      check(sclOut === 1'b0, "R9 low first", int'(sclOut), 0);
      countPhase(1'b0, lowLen, pd, lastPd);
      check(lowLen == eL, "R2 R1 R4 low length", lowLen, eL);
      check(pd == 1 && lastPd, "R8 low strobe", pd, 1);
      countPhase(1'b1, highLen, pd, lastPd);
      check(highLen == eH, "R3 R1 R4 high length", highLen, eH);
      check(pd == 1 && lastPd, "R8 high strobe", pd, 1);
      if (VEC[i][7:0] == VEC[i][15:8])
        check(lowLen == highLen, "R5 symmetric", highLen, lowLen);
      stopRun();
    end

    // R6: word written mid low phase applies from the next low phase
    writeCfg(32'h0000_0A0A);  // 14 / 14
    masterEn = 1'b1; xferActive = 1'b1;
    @(negedge clk);
    lowLen = 0;
    while (sclOut == 1'b0 && lowLen < LIMIT) begin
      lowLen++;
      if (lowLen == 3) begin cfgWrEn = 1'b1; cfgWrData = 32'h0000_0202; end
      else cfgWrEn = 1'b0;
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
    check(lowLen == 14, "R6 current low kept", lowLen, 14);
    countPhase(1'b1, highLen, pd, lastPd);
    check(highLen == 14, "R6 following high kept", highLen, 14);
    countPhase(1'b0, nextLen, pd, lastPd);
    check(nextLen == 6, "R6 next low uses new word", nextLen, 6);
    stopRun();

    // R7: each qualifier alone keeps the clock released
    masterEn = 1'b0; xferActive = 1'b1;
    bad = 0;
    repeat (20) begin @(negedge clk); if (sclOut !== 1'b1 || phaseDone !== 1'b0) bad = 1; end
    check(!bad, "R7 disabled idle", int'(bad), 0);
    masterEn = 1'b1; xferActive = 1'b0;
    bad = 0;
    repeat (20) begin @(negedge clk); if (sclOut !== 1'b1 || phaseDone !== 1'b0) bad = 1; end
    check(!bad, "R7 no transfer idle", int'(bad), 0);

    // R7: dropping the run mid phase releases next cycle
    xferActive = 1'b1;
    repeat (3) @(negedge clk);
    check(sclOut === 1'b0, "R7 running low", int'(sclOut), 0);
    xferActive = 1'b0;
    @(negedge clk);
    check(sclOut === 1'b1 && phaseDone === 1'b0, "R7 abort release", int'(sclOut), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule